// File: doc/BRIEF.md
# Configurable Pin Interrupt Controller

This block turns eight already-selected input pins into eight interrupt request lines. Each channel is configured through a small 32-bit register port as either edge-sensitive or level-sensitive. In edge mode a channel can watch rising edges, falling edges, or both, and a detected edge is latched in a sticky status bit that software clears by writing a one. In level mode the request line follows the pin for as long as it sits at the chosen active level and the channel is enabled.

Every pin passes through a two-flop synchronizer before detection, so the pins may be fully asynchronous to the clock. The primary enable register and the secondary register (falling-edge enable in edge mode, active-level select in level mode) are each reachable directly and through write-one-to-set and write-one-to-clear aliases. This lets software change one channel without a read-modify-write. The pin selection mux, the processor's interrupt controller and any bus bridge sit outside this block.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and every bit of `irq_o` is 0.
- R2: The mode register at offset 0x000 holds one bit per channel in bits 7:0, where 0 selects edge and 1 selects level. Bits 31:8 of every register read as 0.
- R3: The primary enable register at 0x004 is read/write. Writing a 1 to a bit of its set alias at 0x008 sets the matching enable bit, and writing a 1 to a bit of its clear alias at 0x00C clears it. Zero bits written to either alias change nothing, and both aliases read as 0.
- R4: The secondary register at 0x010 is read/write. It has a set alias at 0x014 and a clear alias at 0x018, which behave like the aliases in R3.
- R5: In edge mode with the primary enable bit at 1, a rising pin edge sets the channel's status bit. With the pin applied before clock edge k, `irq_o` shows the new status after edge k+2 and not before.
- R6: In edge mode with the secondary bit at 1, a falling pin edge sets the status bit with the same latency as in R5.
- R7: A status bit, readable at 0x01C, stays set until a 1 is written to that bit at 0x01C. Writing 0 there has no effect. In edge mode `irq_o` equals the status bit.
- R8: In level mode, `irq_o` is 1 while the primary enable is 1 and the synchronized pin equals the secondary bit, where 1 means active HIGH and 0 means active LOW. It responds after edge k+1, and the status bit stays 0.
- R9: A write that changes a channel's mode bit clears that channel's status bit.
- R10: When an edge event and a write-one-to-clear of the same status bit fall in the same cycle, the status bit ends set.
- R11: Edges whose enable bits are 0 leave the status bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 8 | Asynchronous pin inputs, one per channel |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe, 0 otherwise |
| irq_o | output | 8 | Interrupt request per channel |

## Verification
Two things can hit the same status bit in one cycle: a software write-one-to-clear and a newly detected edge. A mode write and an edge event can also coincide. The bench arranges the first case directly by placing the clear write exactly two clocks after a rising pin change, so that both act on the same clock edge. It then requires the bit to read back as set. The randomized phase mixes pin toggles with writes to every register, including status clears and mode flips, so both collisions occur many times. Each outcome is judged against a cycle-accurate bench model in which a set beats a clear, and a mode change beats both.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] OFS_MODE    = 12'h000;
  localparam logic [AW-1:0] OFS_PRI     = 12'h004;
  localparam logic [AW-1:0] OFS_PRI_SET = 12'h008;
  localparam logic [AW-1:0] OFS_PRI_CLR = 12'h00C;
  localparam logic [AW-1:0] OFS_SEC     = 12'h010;
  localparam logic [AW-1:0] OFS_SEC_SET = 12'h014;
  localparam logic [AW-1:0] OFS_SEC_CLR = 12'h018;
  localparam logic [AW-1:0] OFS_STAT    = 12'h01C;

  typedef struct packed {
    logic mode_wr;
    logic pri_wr;
    logic pri_set;
    logic pri_clr;
    logic sec_wr;
    logic sec_set;
    logic sec_clr;
    logic stat_clr;
  } wr_dec_t;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] sync_o,
  output logic [NCH-1:0] dly_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [STAGES-1:0] stage_q, stage_d;
    logic              dly_q;

    always_comb begin
      stage_d = {stage_q[STAGES-2:0], pin_i[c]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        dly_q   <= 1'b0;
      end else begin
        stage_q <= stage_d;
        dly_q   <= stage_q[LAST];
      end
    end

    assign sync_o[c] = stage_q[LAST];
    assign dly_o[c]  = dly_q;
  end
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] status_i,
  output logic [NCH-1:0] mode_o,
  output logic [NCH-1:0] pri_o,
  output logic [NCH-1:0] sec_o,
  output logic [NCH-1:0] mode_chg_o,
  output logic [NCH-1:0] stat_clr_o
);
  localparam int unsigned PAD = DW - NCH;

  logic [NCH-1:0] mode_q, mode_d, pri_q, pri_d, sec_q, sec_d, wbits;
  logic           mode_ce, pri_ce, sec_ce, wr_en, rd_en;
  logic [AW-3:0]  widx;
  wr_dec_t        dec;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;
  assign widx  = bus_addr[AW-1:2];
  assign wbits = bus_wdata[NCH-1:0];

  always_comb begin
    dec          = '0;
    dec.mode_wr  = wr_en & (widx == OFS_MODE[AW-1:2]);
    dec.pri_wr   = wr_en & (widx == OFS_PRI[AW-1:2]);
    dec.pri_set  = wr_en & (widx == OFS_PRI_SET[AW-1:2]);
    dec.pri_clr  = wr_en & (widx == OFS_PRI_CLR[AW-1:2]);
    dec.sec_wr   = wr_en & (widx == OFS_SEC[AW-1:2]);
    dec.sec_set  = wr_en & (widx == OFS_SEC_SET[AW-1:2]);
    dec.sec_clr  = wr_en & (widx == OFS_SEC_CLR[AW-1:2]);
    dec.stat_clr = wr_en & (widx == OFS_STAT[AW-1:2]);
  end

  always_comb begin
    mode_ce = dec.mode_wr;
    mode_d  = wbits;
    pri_ce  = dec.pri_wr | dec.pri_set | dec.pri_clr;
    pri_d   = dec.pri_wr  ? wbits :
              dec.pri_set ? (pri_q | wbits) : (pri_q & ~wbits);
    sec_ce  = dec.sec_wr | dec.sec_set | dec.sec_clr;
    sec_d   = dec.sec_wr  ? wbits :
              dec.sec_set ? (sec_q | wbits) : (sec_q & ~wbits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pri_q  <= '0;
      sec_q  <= '0;
    end else begin
      if (mode_ce) mode_q <= mode_d;
      if (pri_ce)  pri_q  <= pri_d;
      if (sec_ce)  sec_q  <= sec_d;
    end
  end

  assign mode_chg_o = dec.mode_wr  ? (mode_q ^ wbits) : '0;
  assign stat_clr_o = dec.stat_clr ? wbits : '0;
  assign mode_o     = mode_q;
  assign pri_o      = pri_q;
  assign sec_o      = sec_q;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (widx)
        OFS_MODE[AW-1:2]: bus_rdata = {{PAD{1'b0}}, mode_q};
        OFS_PRI[AW-1:2]:  bus_rdata = {{PAD{1'b0}}, pri_q};
        OFS_SEC[AW-1:2]:  bus_rdata = {{PAD{1'b0}}, sec_q};
        OFS_STAT[AW-1:2]: bus_rdata = {{PAD{1'b0}}, status_i};
        default:          bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sync_i,
  input  logic [NCH-1:0] dly_i,
  input  logic [NCH-1:0] mode_i,
  input  logic [NCH-1:0] pri_i,
  input  logic [NCH-1:0] sec_i,
  input  logic [NCH-1:0] mode_chg_i,
  input  logic [NCH-1:0] stat_clr_i,
  output logic [NCH-1:0] status_o,
  output logic [NCH-1:0] irq_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic rise, fall, event_hit, st_q, st_d, st_ce;

    always_comb begin
      rise      = sync_i[c] & ~dly_i[c];
      fall      = ~sync_i[c] & dly_i[c];
      event_hit = ~mode_i[c] & ((pri_i[c] & rise) | (sec_i[c] & fall));
      st_ce     = mode_chg_i[c] | event_hit | (stat_clr_i[c] & st_q);
      if (mode_chg_i[c]) st_d = 1'b0;
      else               st_d = event_hit | (st_q & ~stat_clr_i[c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= 1'b0;
      else if (st_ce) st_q <= st_d;
    end

    assign status_o[c] = st_q;
    assign irq_o[c]    = mode_i[c] ? (pri_i[c] & (sync_i[c] == sec_i[c])) : st_q;
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned NCH     = 8,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq_o
);
  logic [1:0]     rst_pipe_q;
  logic           rst_int_n;
  logic [NCH-1:0] sync_w, dly_w, mode_w, pri_w, sec_w, chg_w, clr_w, status_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pin_irq_sync #(.NCH(NCH), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .pin_i(pin_i), .sync_o(sync_w), .dly_o(dly_w)
  );

  pin_irq_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status_i(status_w), .mode_o(mode_w), .pri_o(pri_w), .sec_o(sec_w),
    .mode_chg_o(chg_w), .stat_clr_o(clr_w)
  );

  pin_irq_detect #(.NCH(NCH)) u_det (
    .clk(clk), .rst_n(rst_int_n), .sync_i(sync_w), .dly_i(dly_w),
    .mode_i(mode_w), .pri_i(pri_w), .sec_i(sec_w), .mode_chg_i(chg_w),
    .stat_clr_i(clr_w), .status_o(status_w), .irq_o(irq_o)
  );
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
  import pin_irq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] mode_w,
  input logic [NCH-1:0] pri_w,
  input logic [NCH-1:0] status_w
);
  logic rd, wr_mode, wr_stat, rd_alias;
  assign rd       = bus_sel & ~bus_wr;
  assign wr_mode  = bus_sel & bus_wr & (bus_addr[AW-1:2] == OFS_MODE[AW-1:2]);
  assign wr_stat  = bus_sel & bus_wr & (bus_addr[AW-1:2] == OFS_STAT[AW-1:2]);
  assign rd_alias = rd & ((bus_addr[AW-1:2] == OFS_PRI_SET[AW-1:2]) |
                          (bus_addr[AW-1:2] == OFS_PRI_CLR[AW-1:2]) |
                          (bus_addr[AW-1:2] == OFS_SEC_SET[AW-1:2]) |
                          (bus_addr[AW-1:2] == OFS_SEC_CLR[AW-1:2]));

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (bus_rdata[DW-1:NCH] == '0)); // R2
  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_alias |-> (bus_rdata == '0)); // R3
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_mode || wr_stat) |=> ((status_w & $past(status_w)) == $past(status_w))); // R7
  AST_LEVEL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & mode_w & ~pri_w) == '0)); // R8
  AST_LEVEL_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_w & mode_w) == '0)); // R9
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .mode_w(mode_w), .pri_w(pri_w), .status_w(status_w)
);

// File: tb/pin_irq_ctrl_test.sv
`timescale 1ns/1ps
module pin_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pin_i;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // bench reference model
  logic [7:0] m_mode, m_pri, m_sec, m_st, m_s1, m_s2, m_d;

  function automatic logic [7:0] f_event(logic [7:0] mo, pr, se, s, d);
    return ~mo & ((pr & s & ~d) | (se & ~s & d));
  endfunction

  function automatic logic [7:0] f_irq();
    return (m_mode & m_pri & ~(m_s2 ^ m_sec)) | (~m_mode & m_st);
  endfunction

  function automatic logic [31:0] f_rd(logic [11:0] a);
    case (a[11:2])
      10'h000: return {24'h0, m_mode};
      10'h001: return {24'h0, m_pri};
      10'h004: return {24'h0, m_sec};
      10'h007: return {24'h0, m_st};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_pri <= 0; m_sec <= 0; m_st <= 0;
      m_s1 <= 0; m_s2 <= 0; m_d <= 0;
    end else begin
      logic [7:0] ev, w, chg, clr;
      ev  = f_event(m_mode, m_pri, m_sec, m_s2, m_d);
      w   = bus_wdata[7:0];
      chg = 0; clr = 0;
      m_s1 <= pin_i; m_s2 <= m_s1; m_d <= m_s2;
      if (bus_sel && bus_wr) begin
        case (bus_addr[11:2])
          10'h000: begin m_mode <= w; chg = m_mode ^ w; end
          10'h001: m_pri <= w;
          10'h002: m_pri <= m_pri | w;
          10'h003: m_pri <= m_pri & ~w;
          10'h004: m_sec <= w;
          10'h005: m_sec <= m_sec | w;
          10'h006: m_sec <= m_sec & ~w;
          10'h007: clr = w;
          default: ;
        endcase
      end
      m_st <= ((m_st & ~clr) | ev) & ~chg;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic [7:0] pins, input logic sel, wr,
                      input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    chk({tag, " irq"}, {24'h0, irq_o}, {24'h0, f_irq()});
    pin_i = pins; bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    if (sel && !wr) chk({tag, " rdata"}, bus_rdata, f_rd(a));
  endtask

  task automatic wr_reg(input string tag, input logic [11:0] a, input logic [31:0] d);
    step(tag, pin_i, 1'b1, 1'b1, a, d);
  endtask
  task automatic rd_reg(input string tag, input logic [11:0] a);
    step(tag, pin_i, 1'b1, 1'b0, a, 32'h0);
  endtask
  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, pin_i, 1'b0, 1'b0, 12'h0, 32'h0);
  endtask
  task automatic setpin(input string tag, input logic [7:0] p);
    step(tag, p, 1'b0, 1'b0, 12'h0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; pin_i = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle("R1", 4);
    // R1 reset state
    chk("R1 irq", {24'h0, irq_o}, 32'h0);
    for (int r = 0; r < 8; r++) begin
      rd_reg("R1", 12'(r * 4)); chk("R1 reg", bus_rdata, 32'h0);
    end
    // R2 mode register, upper bits zero
    wr_reg("R2", 12'h000, 32'hFFFF_FF5A); rd_reg("R2", 12'h000);
    chk("R2 mode", bus_rdata, 32'h0000_005A);
    wr_reg("R2", 12'h000, 32'h0);
    // R3 primary enable and its aliases
    wr_reg("R3", 12'h004, 32'h0F); wr_reg("R3", 12'h008, 32'hF0_0030);
    rd_reg("R3", 12'h004); chk("R3 set", bus_rdata, 32'h3F);
    wr_reg("R3", 12'h00C, 32'h01); wr_reg("R3", 12'h008, 32'h0); wr_reg("R3", 12'h00C, 32'h0);
    rd_reg("R3", 12'h004); chk("R3 clr", bus_rdata, 32'h3E);
    rd_reg("R3", 12'h008); chk("R3 alias read", bus_rdata, 32'h0);
    rd_reg("R3", 12'h00C); chk("R3 alias read", bus_rdata, 32'h0);
    // R4 secondary register and its aliases
    wr_reg("R4", 12'h010, 32'h81); wr_reg("R4", 12'h014, 32'h06); wr_reg("R4", 12'h018, 32'h80);
    rd_reg("R4", 12'h010); chk("R4 sec", bus_rdata, 32'h07);
    rd_reg("R4", 12'h014); chk("R4 alias read", bus_rdata, 32'h0);
    wr_reg("R4", 12'h010, 32'h0); wr_reg("R3", 12'h004, 32'h0);
    // R11 disabled edges
    setpin("R11", 8'hFF); setpin("R11", 8'h00); idle("R11", 4);
    rd_reg("R11", 12'h01C); chk("R11 status", bus_rdata, 32'h0);
    // R5 rising edge latency
    wr_reg("R5", 12'h004, 32'h01);
    setpin("R5", 8'h01); idle("R5", 2);
    chk("R5 early", {31'h0, irq_o[0]}, 32'h0);
    idle("R5", 1);
    chk("R5 irq", {31'h0, irq_o[0]}, 32'h1);
    // R7 sticky, write 0 no effect, write 1 clears
    setpin("R7", 8'h00); idle("R7", 3);
    wr_reg("R7", 12'h01C, 32'h0); idle("R7", 1);
    chk("R7 sticky", {31'h0, irq_o[0]}, 32'h1);
    wr_reg("R7", 12'h01C, 32'h01); idle("R7", 1);
    chk("R7 cleared", {31'h0, irq_o[0]}, 32'h0);
    // R6 falling edge
    wr_reg("R6", 12'h004, 32'h0); wr_reg("R6", 12'h010, 32'h02);
    setpin("R6", 8'h02); idle("R6", 4);
    chk("R6 rise ignored", {31'h0, irq_o[1]}, 32'h0);
    setpin("R6", 8'h00); idle("R6", 3);
    chk("R6 fall", {31'h0, irq_o[1]}, 32'h1);
    wr_reg("R6", 12'h01C, 32'hFF); wr_reg("R6", 12'h010, 32'h0);
    // R8 level mode, active high then low
    wr_reg("R8", 12'h000, 32'h04); wr_reg("R8", 12'h004, 32'h04); wr_reg("R8", 12'h010, 32'h04);
    setpin("R8", 8'h04); idle("R8", 1);
    chk("R8 early", {31'h0, irq_o[2]}, 32'h0);
    idle("R8", 1);
    chk("R8 high", {31'h0, irq_o[2]}, 32'h1);
    setpin("R8", 8'h00); idle("R8", 2);
    chk("R8 drop", {31'h0, irq_o[2]}, 32'h0);
    wr_reg("R8", 12'h018, 32'h04); idle("R8", 1);
    chk("R8 low", {31'h0, irq_o[2]}, 32'h1);
    rd_reg("R8", 12'h01C); chk("R8 status", bus_rdata, 32'h0);
    wr_reg("R8", 12'h000, 32'h0); wr_reg("R8", 12'h004, 32'h0);
    // R9 mode change clears status
    wr_reg("R9", 12'h004, 32'h01); setpin("R9", 8'h01); idle("R9", 3);
    rd_reg("R9", 12'h01C); chk("R9 pre", bus_rdata, 32'h01);
    wr_reg("R9", 12'h00C, 32'h01); wr_reg("R9", 12'h000, 32'h01); idle("R9", 1);
    rd_reg("R9", 12'h01C); chk("R9 cleared", bus_rdata, 32'h0);
    wr_reg("R9", 12'h000, 32'h0); setpin("R9", 8'h00); idle("R9", 3);
    // R10 event and clear on the same edge
    wr_reg("R10", 12'h004, 32'h08); setpin("R10", 8'h08); idle("R10", 3);
    setpin("R10", 8'h00); idle("R10", 3);
    setpin("R10", 8'h08); idle("R10", 1);
    wr_reg("R10", 12'h01C, 32'h08); idle("R10", 1);
    rd_reg("R10", 12'h01C); chk("R10 set wins", bus_rdata, 32'h08);
    // randomized phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] p;
      int unsigned k;
      p = pin_i;
      if ($urandom_range(3) == 0) p = p ^ 8'($urandom_range(255));
      k = $urandom_range(9);
      if (k < 4)      step("R5 rnd", p, 1'b0, 1'b0, 12'h0, 32'h0);
      else if (k < 7) step("R7 rnd", p, 1'b1, 1'b1, 12'($urandom_range(7) * 4), $urandom);
      else            step("R2 rnd", p, 1'b1, 1'b0, 12'($urandom_range(9) * 4), 32'h0);
    end
    idle("R1", 2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule